// File: doc/BRIEF.md
# Cascadable Serial Bitstream Streamer

This block behaves like a serial configuration memory for a programmable logic device. It holds a bitstream of parameterised length in a register array, which is filled through a simple write port. On each rising clock edge it presents the next bit, in ascending address order, on a serial data line. The device being configured samples that line. One shared pin carries both the counter reset and the output enable. A configuration bit selects which level of that pin means "reset".

Several of these blocks can be chained. Each block has an active-low cascade enable output, which feeds the chip enable of the next block. When the last stored bit has been clocked out, a block releases its data line and pulls the cascade output low. The next block then starts driving its own bitstream from its first bit, without a gap. The block cannot see a reset of the device it is configuring. Its address counter is put back in step only through the shared reset/enable pin.

The tri-state data pin is modelled as a value together with a driver enable. The pad sits outside this block.

Top module: `cfg_bit_streamer`

## Requirements
- R1: `dataOe` is 1 only when `ceN` is 0, the reset function is inactive and the last bit has not yet been passed. In every other case `dataOe` is 0 and `dataOut` is 0.
- R2: A rising clock edge with the reset function active clears the address counter and sets `ceoN` to 1. The first bit shown once the reset is released is stored bit 0.
- R3: The reset function is active when `rstOe` differs from `polActLow`. With `polActLow`=0, `rstOe`=1 resets. With `polActLow`=1, `rstOe`=0 resets.
- R4: While the block is enabled, the reset is inactive and the last bit has not been passed, each rising edge advances the address by one. Stored bit k appears on `dataOut` after the k-th edge.
- R5: While `ceN` is 1, the address holds and clock edges have no effect. When `ceN` returns to 0, the block shows the same bit it showed before the pause.
- R6: The edge that follows the display of bit STREAM_LEN-1 sets `ceoN` to 0 and `dataOe` to 0. Both stay that way, with no wrap of the address, for as long as the reset is inactive.
- R7: `ceoN` stays 1 from a reset until the final bit has been sent.
- R8: With a downstream block's `ceN` tied to the upstream `ceoN`, the shared line carries the upstream bitstream followed at once by the downstream bitstream, one bit per clock.
- R9: With `wrEn`=1, a rising edge stores `wrData` at bit address `wrAddr`. Addresses at or beyond STREAM_LEN are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift and write clock |
| ceN | input | 1 | Active-low chip enable |
| rstOe | input | 1 | Combined counter reset / output enable pin |
| polActLow | input | 1 | Reset polarity select: 0 = high resets, 1 = low resets |
| wrEn | input | 1 | Storage write strobe |
| wrAddr | input | ADDR_W | Bit address to write |
| wrData | input | 1 | Bit value to write |
| dataOut | output | 1 | Serial data value |
| dataOe | output | 1 | Serial data driver enable |
| ceoN | output | 1 | Active-low cascade enable for the next block |

## Verification
The hardest case to reach is the cycle where control passes from one block to the next. There the upstream release and the downstream first bit must fall in the same cycle. The bench therefore chains two instances of different lengths and checks the resolved line over the whole combined stream, with a chip-enable pause inserted part way through the upstream stream. After both streams have ended, the bench flips the polarity together with the pin level. This shows that the new inactive level keeps the finished state, and that the new active level clears it. A reset applied mid-stream must restart the stream from bit 0.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  typedef struct packed {
    logic clrAddr;
    logic incAddr;
  } addr_strobe_t;
endpackage

// File: rtl/cfg_stream_dp.sv
module cfg_stream_dp
  import cfg_stream_pkg::*;
#(
  parameter int STREAM_LEN = 64,
  parameter int ADDR_W = $clog2(STREAM_LEN + 1)
) (
  input  logic              clk,
  input  addr_strobe_t      strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrData,
  output logic [ADDR_W-1:0] addr,
  output logic              lastBit,
  output logic              bitOut
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(STREAM_LEN - 1);

  logic [STREAM_LEN-1:0] store;

  // one write decoder per stored bit
  for (genvar i = 0; i < STREAM_LEN; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (wrEn && (wrAddr == ADDR_W'(i))) store[i] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clrAddr)      addr <= '0;
    else if (strobe.incAddr) addr <= addr + 1'b1;
  end

  assign lastBit = (addr == LAST_ADDR);

  always_comb begin
    bitOut = 1'b0;
    for (int k = 0; k < STREAM_LEN; k++) begin
      if (addr == ADDR_W'(k)) bitOut = store[k];
    end
  end

  // R6: the counter never steps past the final bit
  always_comb begin
    if (strobe.incAddr === 1'b1)
      assert_no_overflow_R6: assert (addr !== LAST_ADDR);
  end
endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
  import cfg_stream_pkg::*;
(
  input  logic         clk,
  input  logic         ceN,
  input  logic         rstOe,
  input  logic         polActLow,
  input  logic         lastBit,
  output addr_strobe_t strobe,
  output logic         done,
  output logic         resetActive,
  output logic         driveEn
);
  logic primed = 1'b0;

  assign resetActive    = rstOe ^ polActLow;
  assign strobe.clrAddr = resetActive;
  assign strobe.incAddr = !resetActive && !ceN && !done && !lastBit;
  assign driveEn        = !ceN && !resetActive && !done;

  always_ff @(posedge clk) begin
    if (resetActive)                   done <= 1'b0;
    else if (!ceN && !done && lastBit) done <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (resetActive) primed <= 1'b1;
  end

  // R6: once finished, the state sticks until a reset
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (resetActive || !primed)
    done |=> done);

  // R7: the finish flag rises only on the last bit with the chip enabled
  assert_done_rise_R7: assert property (@(posedge clk) disable iff (resetActive || !primed)
    !done |=> (!done || $past(lastBit && !ceN)));

  // R2: an active reset edge clears the finished state
  assert_clear_done_R2: assert property (@(posedge clk) disable iff (!primed)
    resetActive |=> !done);
endmodule

// File: rtl/cfg_bit_streamer.sv
module cfg_bit_streamer
  import cfg_stream_pkg::*;
#(
  parameter int STREAM_LEN = 64,
  parameter int ADDR_W = $clog2(STREAM_LEN + 1)
) (
  input  logic              clk,
  input  logic              ceN,
  input  logic              rstOe,
  input  logic              polActLow,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrData,
  output logic              dataOut,
  output logic              dataOe,
  output logic              ceoN
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(STREAM_LEN - 1);

  addr_strobe_t      strobe;
  logic [ADDR_W-1:0] addr;
  logic              lastBit, bitOut, done, resetActive, driveEn;
  logic              primed = 1'b0;

  cfg_stream_ctrl u_ctrl (
    .clk(clk), .ceN(ceN), .rstOe(rstOe), .polActLow(polActLow),
    .lastBit(lastBit), .strobe(strobe), .done(done),
    .resetActive(resetActive), .driveEn(driveEn)
  );

  cfg_stream_dp #(.STREAM_LEN(STREAM_LEN), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .strobe(strobe), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .addr(addr), .lastBit(lastBit), .bitOut(bitOut)
  );

  assign ceoN    = ~done;
  assign dataOe  = driveEn;
  assign dataOut = driveEn & bitOut;

  always_ff @(posedge clk) begin
    if (resetActive) primed <= 1'b1;
  end

  // R1: never drive while disabled, in reset or after handoff
  assert_drive_gate_R1: assert property (@(posedge clk) disable iff (!primed)
    dataOe |-> (!ceN && (rstOe == polActLow) && ceoN));

  // R2: reset edge returns the counter to bit 0
  assert_clear_addr_R2: assert property (@(posedge clk) disable iff (!primed)
    (rstOe != polActLow) |=> (addr == '0 && ceoN));

  // R4: one step per enabled edge
  assert_step_R4: assert property (@(posedge clk) disable iff (resetActive || !primed)
    (!ceN && ceoN && addr != LAST_ADDR) |=> (addr == $past(addr) + 1'b1));

  // R5: chip enable high freezes the counter
  assert_hold_R5: assert property (@(posedge clk) disable iff (resetActive || !primed)
    ceN |=> $stable(addr) && $stable(ceoN));
endmodule

// File: tb/tb_cfg_bit_streamer.sv
`timescale 1ns/1ps
module tb_cfg_bit_streamer;
  localparam int LEN_U = 12;
  localparam int LEN_D = 7;
  localparam int AW_U = $clog2(LEN_U + 1);
  localparam int AW_D = $clog2(LEN_D + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic upCeN, rstOe, polActLow;
  logic upWrEn, dnWrEn, wrData;
  logic [AW_U-1:0] upWrAddr;
  logic [AW_D-1:0] dnWrAddr;
  logic upOut, upOe, upCeoN, dnOut, dnOe, dnCeoN;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  cfg_bit_streamer #(.STREAM_LEN(LEN_U)) dut (
    .clk(clk), .ceN(upCeN), .rstOe(rstOe), .polActLow(polActLow),
    .wrEn(upWrEn), .wrAddr(upWrAddr), .wrData(wrData),
    .dataOut(upOut), .dataOe(upOe), .ceoN(upCeoN)
  );

  cfg_bit_streamer #(.STREAM_LEN(LEN_D)) dut_dn (
    .clk(clk), .ceN(upCeoN), .rstOe(rstOe), .polActLow(polActLow),
    .wrEn(dnWrEn), .wrAddr(dnWrAddr), .wrData(wrData),
    .dataOut(dnOut), .dataOe(dnOe), .ceoN(dnCeoN)
  );

  function automatic logic pat(int dev, int i);
    return 1'(((i * 7 + dev * 3 + 1) / 3) & 1) ^ 1'(i % 4 == 0);
  endfunction

  function automatic logic lineVal();
    return upOe ? upOut : (dnOe ? dnOut : 1'b1);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    upCeN = 1'b1; rstOe = 1'b1; polActLow = 1'b0;
    upWrEn = 1'b0; dnWrEn = 1'b0; wrData = 1'b0; upWrAddr = '0; dnWrAddr = '0;
    #1;
    // R9: preload both storage arrays, plus an out-of-range address
    for (int i = 0; i < LEN_U; i++) begin
      upWrEn = 1'b1; upWrAddr = AW_U'(i); wrData = pat(0, i);
      dnWrEn = (i < LEN_D); dnWrAddr = AW_D'(i % LEN_D); if (i < LEN_D) wrData = pat(0, i);
      if (i < LEN_D && pat(0, i) != pat(1, i)) begin
        tick();
        upWrEn = 1'b0; dnWrAddr = AW_D'(i); wrData = pat(1, i);
      end
      tick();
      if (i < LEN_D) begin
        upWrEn = 1'b0; dnWrAddr = AW_D'(i); wrData = pat(1, i); tick();
      end
    end
    upWrEn = 1'b1; upWrAddr = AW_U'(LEN_U); wrData = ~pat(0, 0); dnWrEn = 1'b0;
    tick();
    upWrEn = 1'b0;
    tick();
    // R1 R2 R7: reset state (polarity 0, pin high = reset)
    check("R1 up oe in reset", upOe, 1'b0);
    check("R1 dn oe in reset", dnOe, 1'b0);
    check("R7 up ceoN after reset", upCeoN, 1'b1);
    check("R7 dn ceoN after reset", dnCeoN, 1'b1);

    // R4 R5 R8: full chained readout
    rstOe = 1'b0; upCeN = 1'b0; #1;
    for (int j = 0; j < LEN_U + LEN_D; j++) begin
      if (j == 5) begin
        upCeN = 1'b1; #1;
        check("R1 up oe with ceN high", upOe, 1'b0);
        for (int p = 0; p < 3; p++) tick();
        check("R5 ceoN held in pause", upCeoN, 1'b1);
        upCeN = 1'b0; #1;
      end
      if (j < LEN_U) begin
        check("R4 upstream bit", lineVal(), pat(0, j));
        check("R7 ceoN high mid stream", upCeoN, 1'b1);
      end else begin
        check("R8 downstream bit", lineVal(), pat(1, j - LEN_U));
        check("R6 up released after handoff", upOe, 1'b0);
      end
      tick();
    end
    check("R6 up ceoN low at end", upCeoN, 1'b0);
    check("R6 dn ceoN low at end", dnCeoN, 1'b0);
    check("R6 dn oe off at end", dnOe, 1'b0);
    for (int p = 0; p < 3; p++) tick();
    check("R6 up oe stays off", upOe, 1'b0);
    check("R6 up ceoN stays low", upCeoN, 1'b0);
    check("R6 line idle", lineVal(), 1'b1);

    // R3: flip polarity, high is now inactive and keeps the finished state
    polActLow = 1'b1; rstOe = 1'b1; #1;
    tick(); tick();
    check("R3 inactive high keeps state", upCeoN, 1'b0);
    rstOe = 1'b0; #1;
    check("R1 oe off with low reset", upOe, 1'b0);
    tick();
    check("R3 low resets up ceoN", upCeoN, 1'b1);
    check("R2 low resets dn ceoN", dnCeoN, 1'b1);
    rstOe = 1'b1; #1;
    check("R2 restart at bit 0", lineVal(), pat(0, 0));
    check("R1 oe on after release", upOe, 1'b1);
    tick(); tick(); tick();
    check("R4 bit 3 after restart", lineVal(), pat(0, 3));
    rstOe = 1'b0; tick();
    rstOe = 1'b1; #1;
    check("R2 mid stream reset to bit 0", lineVal(), pat(0, 0));

    // R3: polarity back to 0, mid-stream high reset
    polActLow = 1'b0; rstOe = 1'b0; #1;
    tick(); tick();
    check("R4 bit 2 polarity 0", lineVal(), pat(0, 2));
    rstOe = 1'b1; #1;
    check("R3 high reset disables", upOe, 1'b0);
    tick();
    rstOe = 1'b0; #1;
    check("R3 high reset restarts bit 0", lineVal(), pat(0, 0));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule